// File: doc/BRIEF.md
# Paged system address decoder

This block takes a 32-bit processor address and steers it to one of ten targets, using the top address byte as a page number. The targets are the boot ROM, external work RAM, internal work RAM, the I/O window, palette RAM, video RAM, object attribute RAM, cartridge ROM, cartridge save RAM and a dummy sink. The dummy sink discards writes and returns zero on reads. For each target the block also gives the device-local offset, with that region's mirroring rule applied.

The processor presents an address, an access width and a read/write flag, and raises a strobe. One clock edge later the block returns a one-hot target select, the offset, a flag for an unaligned input address and a flag for an access to an unmapped page. Reads and writes are routed differently for the boot ROM and for the cartridge ROM windows. The outputs hold their values between strobes.

Top module: `sys_addr_decoder`

## Requirements
- R1: Page = addr[31:24]. Reads route as follows: 0x00 to boot ROM (target bit 0), 0x02 to external RAM (bit 1), 0x03 to internal RAM (bit 2), 0x04 to I/O (bit 3), 0x05 to palette (bit 4), 0x06 to video RAM (bit 5), 0x07 to object RAM (bit 6), 0x08 through 0x0D to cartridge ROM (bit 7), and 0x0E and 0x0F to save RAM (bit 8). Boot ROM, cartridge ROM, save RAM and dummy (bit 9) offsets are the full aligned address.
- R2: The external RAM offset is the aligned address masked to 18 bits. The internal RAM offset is masked to 15 bits.
- R3: The I/O offset is the aligned address masked to 11 bits. When the aligned address's low 16 bits equal 0x8000, the offset is 0x800 instead.
- R4: Palette and object RAM offsets are the aligned address masked to 10 bits.
- R5: The video RAM offset is the aligned address masked to 17 bits. A masked value strictly greater than 0x18000 has 0x8000 subtracted from it.
- R6: A boot ROM read at an aligned address of 0x4000 or above goes to dummy. Every write to page 0x00 goes to dummy. Neither case raises invalid_o.
- R7: Writes to pages 0x08 and 0x09 go to dummy without invalid_o. Writes to pages 0x0A through 0x0C go to dummy with invalid_o set. Writes to page 0x0D go to cartridge ROM. Writes to pages 0x0E and 0x0F go to save RAM.
- R8: width_i encodes 0 = byte, 1 = half, 2 or 3 = word. A word access clears address bits 1:0 and a half access clears bit 0 before decoding. unaligned_o is set when any cleared bit was 1. Byte accesses are never unaligned.
- R9: Page 0x01 and pages 0x10 and above route to dummy and set invalid_o.
- R10: All outputs update only on the clock edge where valid_i is high. valid_o is high for exactly the cycle after a strobe. When valid_i is low, the outputs hold their values.
- R11: After reset, valid_o, target_o, offset_o, unaligned_o and invalid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access strobe |
| addr_i | input | 32 | Processor address |
| width_i | input | 2 | Access width code |
| write_i | input | 1 | 1 = write, 0 = read |
| valid_o | output | 1 | Decoded result valid |
| target_o | output | 10 | One-hot target select |
| offset_o | output | 32 | Device-local offset |
| unaligned_o | output | 1 | Input address was misaligned |
| invalid_o | output | 1 | Unmapped access |

## Verification
The bench builds the decoder with its default parameters. These are an 18-bit external RAM window, a 15-bit internal RAM window, an 11-bit I/O window, a 10-bit window for palette and object RAM, a 17-bit video RAM window with its fold threshold at 0x18000, and a 0x4000-byte boot ROM. With these values every mirroring edge can be reached using short directed addresses: the unfolded value exactly at the video threshold, the first folded value just above it, the first boot ROM address that falls outside the ROM, and the special I/O location.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned N_TGT = 10;

  typedef enum logic [3:0] {
    T_BIOS  = 4'd0,
    T_EWRAM = 4'd1,
    T_IWRAM = 4'd2,
    T_IO    = 4'd3,
    T_PAL   = 4'd4,
    T_VRAM  = 4'd5,
    T_OAM   = 4'd6,
    T_ROM   = 4'd7,
    T_SRAM  = 4'd8,
    T_DUMMY = 4'd9
  } tgt_e;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_WRD2 = 2'd3
  } width_e;
endpackage

// File: rtl/sad_align.sv
module sad_align
  import sad_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    width_i,
  output logic [AW-1:0] addr_o,
  output logic          unaligned_o
);
  always_comb begin
    addr_o      = addr_i;
    unaligned_o = 1'b0;
    unique case (width_e'(width_i))
      W_BYTE: ;
      W_HALF: begin
        addr_o[0]   = 1'b0;
        unaligned_o = addr_i[0];
      end
      default: begin
        addr_o[1:0] = 2'b00;
        unaligned_o = |addr_i[1:0];
      end
    endcase
  end
endmodule

// File: rtl/sad_region.sv
module sad_region
  import sad_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BIOS_SIZE = 32'h4000
) (
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  output tgt_e          tgt_o,
  output logic          invalid_o
);
  localparam int unsigned PW = 8;
  localparam logic [AW-1:0] BIOS_LIM = AW'(BIOS_SIZE);

  logic [PW-1:0] page;
  assign page = addr_i[AW-1 -: PW];

  always_comb begin
    tgt_o     = T_DUMMY;
    invalid_o = 1'b0;
    case (page)
      8'h00: tgt_o = (write_i || addr_i >= BIOS_LIM) ? T_DUMMY : T_BIOS;
      8'h02: tgt_o = T_EWRAM;
      8'h03: tgt_o = T_IWRAM;
      8'h04: tgt_o = T_IO;
      8'h05: tgt_o = T_PAL;
      8'h06: tgt_o = T_VRAM;
      8'h07: tgt_o = T_OAM;
      8'h08, 8'h09: tgt_o = write_i ? T_DUMMY : T_ROM;
      8'h0A, 8'h0B, 8'h0C: begin
        tgt_o     = write_i ? T_DUMMY : T_ROM;
        invalid_o = write_i;
      end
      8'h0D: tgt_o = T_ROM;
      8'h0E, 8'h0F: tgt_o = T_SRAM;
      default: invalid_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sad_fold.sv
module sad_fold
  import sad_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned EWRAM_AW = 18,
  parameter int unsigned IWRAM_AW = 15,
  parameter int unsigned IO_AW    = 11,
  parameter int unsigned SMALL_AW = 10,
  parameter int unsigned VRAM_AW  = 17,
  parameter int unsigned VRAM_TH  = 32'h18000,
  parameter int unsigned VRAM_SUB = 32'h8000,
  parameter int unsigned IO_ALIAS = 16'h8000
) (
  input  tgt_e          tgt_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] offset_o
);
  localparam logic [AW-1:0] EW_MASK  = (AW'(1) << EWRAM_AW) - AW'(1);
  localparam logic [AW-1:0] IW_MASK  = (AW'(1) << IWRAM_AW) - AW'(1);
  localparam logic [AW-1:0] IO_MASK  = (AW'(1) << IO_AW) - AW'(1);
  localparam logic [AW-1:0] IO_EXTRA = AW'(1) << IO_AW;
  localparam logic [AW-1:0] SM_MASK  = (AW'(1) << SMALL_AW) - AW'(1);
  localparam logic [AW-1:0] VR_MASK  = (AW'(1) << VRAM_AW) - AW'(1);

  logic [AW-1:0] vram_m;
  assign vram_m = addr_i & VR_MASK;

  always_comb begin
    unique case (tgt_i)
      T_EWRAM:     offset_o = addr_i & EW_MASK;
      T_IWRAM:     offset_o = addr_i & IW_MASK;
      T_IO:        offset_o = (addr_i[15:0] == 16'(IO_ALIAS)) ? IO_EXTRA : (addr_i & IO_MASK);
      T_PAL, T_OAM: offset_o = addr_i & SM_MASK;
      T_VRAM:      offset_o = (vram_m > AW'(VRAM_TH)) ? vram_m - AW'(VRAM_SUB) : vram_m;
      default:     offset_o = addr_i;
    endcase
  end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import sad_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BIOS_SIZE = 32'h4000,
  parameter int unsigned EWRAM_AW  = 18,
  parameter int unsigned IWRAM_AW  = 15,
  parameter int unsigned IO_AW     = 11,
  parameter int unsigned SMALL_AW  = 10,
  parameter int unsigned VRAM_AW   = 17,
  parameter int unsigned VRAM_TH   = 32'h18000,
  parameter int unsigned VRAM_SUB  = 32'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        width_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic [N_TGT-1:0]  target_o,
  output logic [AW-1:0]     offset_o,
  output logic              unaligned_o,
  output logic              invalid_o
);
  logic [AW-1:0]    addr_al, offset_d;
  logic             unal_d, inv_d;
  tgt_e             tgt_d;
  logic [N_TGT-1:0] sel_d;

  sad_align #(.AW(AW)) u_align (
    .addr_i(addr_i), .width_i(width_i), .addr_o(addr_al), .unaligned_o(unal_d)
  );

  sad_region #(.AW(AW), .BIOS_SIZE(BIOS_SIZE)) u_region (
    .addr_i(addr_al), .write_i(write_i), .tgt_o(tgt_d), .invalid_o(inv_d)
  );

  sad_fold #(
    .AW(AW), .EWRAM_AW(EWRAM_AW), .IWRAM_AW(IWRAM_AW), .IO_AW(IO_AW),
    .SMALL_AW(SMALL_AW), .VRAM_AW(VRAM_AW), .VRAM_TH(VRAM_TH), .VRAM_SUB(VRAM_SUB)
  ) u_fold (
    .tgt_i(tgt_d), .addr_i(addr_al), .offset_o(offset_d)
  );

  for (genvar g = 0; g < N_TGT; g++) begin : g_sel
    assign sel_d[g] = (tgt_d == tgt_e'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      target_o    <= '0;
      offset_o    <= '0;
      unaligned_o <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        target_o    <= sel_d;
        offset_o    <= offset_d;
        unaligned_o <= unal_d;
        invalid_o   <= inv_d;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(target_o) == 1); // R1
  AST_INVALID_TO_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o |-> target_o[T_DUMMY]); // R9
  AST_WRITE_NO_BIOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && write_i |=> !target_o[T_BIOS]); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && width_i[1] |=> offset_o[1:0] == 2'b00); // R8
  AST_BYTE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && width_i == 2'd0 |=> !unaligned_o); // R8
  AST_VRAM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && target_o[T_VRAM] |-> offset_o <= AW'(VRAM_TH)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(target_o) && $stable(offset_o) && !valid_o); // R10
endmodule

// File: tb/sys_addr_decoder_test.sv
module sys_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  width_i = '0;
  logic        write_i = 1'b0;
  logic        valid_o, unaligned_o, invalid_o;
  logic [9:0]  target_o;
  logic [31:0] offset_o;
  int n_chk = 0, n_fail = 0;

  localparam int BI = 0, EW = 1, IW = 2, IO = 3, PA = 4, VR = 5, OA = 6, RO = 7, SR = 8, DU = 9;

  always #2.5 clk = ~clk;

  sys_addr_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .addr_i(addr_i), .width_i(width_i),
    .write_i(write_i), .valid_o(valid_o), .target_o(target_o), .offset_o(offset_o),
    .unaligned_o(unaligned_o), .invalid_o(invalid_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(logic [31:0] a, logic [1:0] w, logic wr);
    @(negedge clk);
    addr_i = a; width_i = w; write_i = wr; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_out(string req, int tgt, logic [31:0] off, logic unal, logic inv);
    chk({req, " valid"}, 64'(valid_o), 64'd1);
    chk({req, " target"}, 64'(target_o), 64'(10'(1) << tgt));
    chk({req, " offset"}, 64'(offset_o), 64'(off));
    chk({req, " unaligned"}, 64'(unaligned_o), 64'(unal));
    chk({req, " invalid"}, 64'(invalid_o), 64'(inv));
  endtask

  task automatic t_reset;
    chk("R11 valid", 64'(valid_o), 0);
    chk("R11 target", 64'(target_o), 0);
    chk("R11 offset", 64'(offset_o), 0);
    chk("R11 flags", 64'({unaligned_o, invalid_o}), 0);
  endtask

  task automatic t_pages;
    access(32'h0000_1234, 2'd0, 0); expect_out("R1 bios", BI, 32'h0000_1234, 0, 0);
    access(32'h0800_0100, 2'd1, 0); expect_out("R1 rom08", RO, 32'h0800_0100, 0, 0);
    access(32'h0D00_0010, 2'd2, 0); expect_out("R1 rom0d", RO, 32'h0D00_0010, 0, 0);
    access(32'h0E00_0005, 2'd0, 0); expect_out("R1 sram", SR, 32'h0E00_0005, 0, 0);
  endtask

  task automatic t_wram;
    access(32'h0204_0010, 2'd2, 0); expect_out("R2 ewram", EW, 32'h10, 0, 0);
    access(32'h0300_9004, 2'd1, 0); expect_out("R2 iwram", IW, 32'h1004, 0, 0);
  endtask

  task automatic t_io;
    access(32'h0400_0A02, 2'd1, 0); expect_out("R3 mask", IO, 32'h202, 0, 0);
    access(32'h0401_8000, 2'd2, 1); expect_out("R3 alias", IO, 32'h800, 0, 0);
    access(32'h0400_0802, 2'd1, 0); expect_out("R3 wrap", IO, 32'h002, 0, 0);
  endtask

  task automatic t_small;
    access(32'h0500_0C06, 2'd1, 0); expect_out("R4 pal", PA, 32'h006, 0, 0);
    access(32'h0700_07FE, 2'd1, 1); expect_out("R4 oam", OA, 32'h3FE, 0, 0);
  endtask

  task automatic t_vram;
    access(32'h0601_8000, 2'd2, 0); expect_out("R5 edge", VR, 32'h18000, 0, 0);
    access(32'h0601_8004, 2'd2, 0); expect_out("R5 fold", VR, 32'h10004, 0, 0);
    access(32'h0602_0008, 2'd1, 0); expect_out("R5 mirror", VR, 32'h8, 0, 0);
  endtask

  task automatic t_bios;
    access(32'h0000_4000, 2'd2, 0); expect_out("R6 high", DU, 32'h4000, 0, 0);
    access(32'h0000_3FFC, 2'd2, 0); expect_out("R6 last", BI, 32'h3FFC, 0, 0);
    access(32'h0000_0010, 2'd2, 1); expect_out("R6 write", DU, 32'h10, 0, 0);
  endtask

  task automatic t_rom_writes;
    access(32'h0800_0000, 2'd1, 1); expect_out("R7 w08", DU, 32'h0800_0000, 0, 0);
    access(32'h0900_0040, 2'd1, 1); expect_out("R7 w09", DU, 32'h0900_0040, 0, 0);
    access(32'h0B00_0000, 2'd1, 1); expect_out("R7 w0b", DU, 32'h0B00_0000, 0, 1);
    access(32'h0A00_0000, 2'd1, 0); expect_out("R7 r0a", RO, 32'h0A00_0000, 0, 0);
    access(32'h0D00_0020, 2'd1, 1); expect_out("R7 w0d", RO, 32'h0D00_0020, 0, 0);
    access(32'h0F00_0001, 2'd0, 1); expect_out("R7 wsram", SR, 32'h0F00_0001, 0, 0);
  endtask

  task automatic t_align;
    access(32'h0300_0003, 2'd2, 0); expect_out("R8 word", IW, 32'h0, 1, 0);
    access(32'h0300_0003, 2'd1, 0); expect_out("R8 half", IW, 32'h2, 1, 0);
    access(32'h0300_0003, 2'd0, 0); expect_out("R8 byte", IW, 32'h3, 0, 0);
    access(32'h0300_0006, 2'd3, 0); expect_out("R8 word3", IW, 32'h4, 1, 0);
  endtask

  task automatic t_unmapped;
    access(32'h0100_0000, 2'd0, 0); expect_out("R9 p01", DU, 32'h0100_0000, 0, 1);
    access(32'h1000_0000, 2'd2, 1); expect_out("R9 p10", DU, 32'h1000_0000, 0, 1);
  endtask

  task automatic t_hold;
    access(32'h0500_0010, 2'd1, 0);
    @(negedge clk);
    addr_i = 32'h0100_0001; width_i = 2'd0; write_i = 1'b1;
    @(negedge clk);
    chk("R10 valid low", 64'(valid_o), 0);
    chk("R10 target held", 64'(target_o), 64'(10'(1) << PA));
    chk("R10 offset held", 64'(offset_o), 64'h10);
    chk("R10 invalid held", 64'(invalid_o), 0);
  endtask

  initial begin
    #1 t_reset;
    #20 rst_n = 1'b1;
    t_reset;
    t_pages; t_wram; t_io; t_small; t_vram; t_bios; t_rom_writes; t_align; t_unmapped; t_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule